// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block holds the interrupt state of a serial port. Every clock it looks at the live conditions of the receive and transmit paths: the receive fill count against a programmable trigger level, the receive empty and full conditions, and the transmit empty and full flags. It also looks at five one-cycle event pulses: receive overrun, framing error, parity error, receive timeout and modem status change. Any condition or event seen at a clock edge sets its bit in a sticky status register. That bit stays set until software clears it by writing a one to it.

The enable mask is never written directly. Writing the set register ORs bits into the mask, and writing the clear register removes bits from it. A single level interrupt goes high whenever a sticky bit is set and its mask bit is also set.

Software reaches the block over a 32-bit word bus with byte offsets. It has single-cycle read and write strobes and no back-pressure. The bus is a control path, so no valid/ready handshake is used: every strobe completes in the cycle it is presented. The FIFOs, the shifter and the baud generator sit outside this block and are seen only through its status inputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0, the sticky status reads 0, the trigger register reads 0x20 and `irq_o` is low.
- R2: A read of offset 0x2C returns the live status, sampled at the read edge. Bit 0 is rx_count >= trigger, bit 1 is rx_count == 0, bit 2 is rx_count == RX_DEPTH, bit 3 is tx_empty_i and bit 4 is tx_full_i. All other bits read 0.
- R3: A live status bit that is high at a clock edge sets the same bit (4:0) of the sticky status register. The bit stays set after the condition goes away.
- R4: An event pulse at a clock edge sets a sticky bit: overrun sets bit 5, framing bit 6, parity bit 7, timeout bit 8 and modem change bit 9.
- R5: A write to offset 0x08 ORs wdata[9:0] into the mask.
- R6: A write to offset 0x0C clears each mask bit whose wdata bit is 1.
- R7: Writes to offset 0x10 (mask read-back) and to offset 0x2C (live status) change no state.
- R8: A write to offset 0x14 clears each sticky bit whose wdata bit is 1 and leaves the other bits unchanged. Offset 0x14 reads back the sticky bits in [9:0].
- R9: When a hardware set and a software clear hit the same sticky bit at the same edge, the bit ends up set.
- R10: `irq_o` is high exactly when some bit is set in both the mask and the sticky status. It follows the registers in the same cycle they update.
- R11: Offset 0x20 is the receive trigger register. It is read/write in bits [TRIG_W-1:0] and sets the threshold used by live bit 0.
- R12: `rdata_o` is loaded at the edge where `rd_en_i` is high, using the values before that edge, and holds otherwise. Offsets 0x08, 0x0C and any unmapped offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_full_i | input | 1 | Transmit FIFO full |
| evt_overrun_i | input | 1 | Receive overrun pulse |
| evt_frame_i | input | 1 | Framing error pulse |
| evt_parity_i | input | 1 | Parity error pulse |
| evt_timeout_i | input | 1 | Receive timeout pulse |
| evt_modem_i | input | 1 | Modem status change pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
Mask, sticky status and trigger change at the first rising edge after a strobe or condition is applied. `irq_o` reflects that change in the same cycle. Read data is captured at the edge that samples `rd_en_i` and reflects the state from before that edge, so a read and a write in the same cycle return the old value. The bench drives every input on the falling edge and updates its model as the rising edge would. It compares `irq_o` and any read data at the next falling edge, exactly one rising edge after each stimulus.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_LIVE = 5;
  localparam int NUM_EVT  = 5;
  localparam int NUM_SRC  = NUM_LIVE + NUM_EVT;

  // byte offsets of the register window
  localparam int OFF_MASK_SET = 'h08;
  localparam int OFF_MASK_CLR = 'h0C;
  localparam int OFF_MASK     = 'h10;
  localparam int OFF_STICKY   = 'h14;
  localparam int OFF_TRIG     = 'h20;
  localparam int OFF_LIVE     = 'h2C;

  localparam int TRIG_RESET = 'h20;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK_SET, SEL_MASK_CLR, SEL_MASK, SEL_STICKY, SEL_TRIG, SEL_LIVE
  } reg_sel_e;
endpackage

// File: rtl/uart_irq_live.sv
module uart_irq_live
  import uart_irq_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int CNT_W    = 5,
  parameter int TRIG_W   = 6
) (
  input  logic [CNT_W-1:0]    rx_count_i,
  input  logic [TRIG_W-1:0]   trig_i,
  input  logic                tx_empty_i,
  input  logic                tx_full_i,
  output logic [NUM_LIVE-1:0] live_o
);
  localparam int CMP_W = (CNT_W > TRIG_W) ? CNT_W : TRIG_W;

  logic [CMP_W-1:0] cnt_ext, trig_ext;

  always_comb begin
    cnt_ext   = CMP_W'(rx_count_i);
    trig_ext  = CMP_W'(trig_i);
    live_o[0] = cnt_ext >= trig_ext;
    live_o[1] = rx_count_i == '0;
    live_o[2] = rx_count_i == CNT_W'(RX_DEPTH);
    live_o[3] = tx_empty_i;
    live_o[4] = tx_full_i;
  end
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  // per bit: a hardware set overrides a same-edge software clear
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt[i] = set_i[i] | (q_o[i] & ~clr_i[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt;
  end
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q_o <= '0;
    else if (set_en_i) q_o <= q_o | bits_i;
    else if (clr_en_i) q_o <= q_o & ~bits_i;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter  int RX_DEPTH = 16,
  parameter  int ADDR_W   = 8,
  parameter  int TRIG_W   = 6,
  localparam int CNT_W    = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              tx_empty_i,
  input  logic              tx_full_i,
  input  logic              evt_overrun_i,
  input  logic              evt_frame_i,
  input  logic              evt_parity_i,
  input  logic              evt_timeout_i,
  input  logic              evt_modem_i,
  output logic              irq_o
);
  reg_sel_e            sel;
  logic [NUM_LIVE-1:0] live_w;
  logic [NUM_SRC-1:0]  set_w, clr_w, sticky_q, mask_q;
  logic [TRIG_W-1:0]   trig_q;
  logic [31:0]         rd_mux;

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFF_MASK_SET): sel = SEL_MASK_SET;
      ADDR_W'(OFF_MASK_CLR): sel = SEL_MASK_CLR;
      ADDR_W'(OFF_MASK):     sel = SEL_MASK;
      ADDR_W'(OFF_STICKY):   sel = SEL_STICKY;
      ADDR_W'(OFF_TRIG):     sel = SEL_TRIG;
      ADDR_W'(OFF_LIVE):     sel = SEL_LIVE;
      default:               sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          trig_q <= TRIG_W'(TRIG_RESET);
    else if (wr_en_i && sel == SEL_TRIG) trig_q <= wdata_i[TRIG_W-1:0];
  end

  uart_irq_live #(.RX_DEPTH(RX_DEPTH), .CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_live (
    .rx_count_i(rx_count_i),
    .trig_i    (trig_q),
    .tx_empty_i(tx_empty_i),
    .tx_full_i (tx_full_i),
    .live_o    (live_w)
  );

  assign set_w = {evt_modem_i, evt_timeout_i, evt_parity_i, evt_frame_i, evt_overrun_i, live_w};
  assign clr_w = (wr_en_i && sel == SEL_STICKY) ? wdata_i[NUM_SRC-1:0] : '0;

  uart_irq_sticky #(.W(NUM_SRC)) u_sticky (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(set_w),
    .clr_i(clr_w),
    .q_o  (sticky_q)
  );

  uart_irq_mask #(.W(NUM_SRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en_i(wr_en_i && sel == SEL_MASK_SET),
    .clr_en_i(wr_en_i && sel == SEL_MASK_CLR),
    .bits_i  (wdata_i[NUM_SRC-1:0]),
    .q_o     (mask_q)
  );

  always_comb begin
    case (sel)
      SEL_MASK:   rd_mux = 32'(mask_q);
      SEL_STICKY: rd_mux = 32'(sticky_q);
      SEL_TRIG:   rd_mux = 32'(trig_q);
      SEL_LIVE:   rd_mux = 32'(live_w);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign irq_o = |(mask_q & sticky_q);
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic [NUM_LIVE-1:0] live_w,
  input logic [NUM_EVT-1:0] evt_w,
  input logic [NUM_SRC-1:0] sticky_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               irq_o
);
  // R3
  live_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|live_w) |=> ((sticky_q[NUM_LIVE-1:0] & $past(live_w)) == $past(live_w)));

  // R4
  event_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_w) |=> ((sticky_q[NUM_SRC-1:NUM_LIVE] & $past(evt_w)) == $past(evt_w)));

  // R5
  mask_set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(OFF_MASK_SET)) |=>
      ((mask_q & $past(wdata_i[NUM_SRC-1:0])) == $past(wdata_i[NUM_SRC-1:0])));

  // R6
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(OFF_MASK_CLR)) |=>
      ((mask_q & $past(wdata_i[NUM_SRC-1:0])) == '0));

  // R7
  mask_direct_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(OFF_MASK)) |=> $stable(mask_q));

  // R10
  irq_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sticky_q != '0 && mask_q != '0));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .live_w  (live_w),
  .evt_w   (set_w[uart_irq_pkg::NUM_SRC-1:uart_irq_pkg::NUM_LIVE]),
  .sticky_q(sticky_q),
  .mask_q  (mask_q),
  .irq_o   (irq_o)
);

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [CW-1:0] cnt = CW'(1);
  logic txe = 1'b0, txf = 1'b0;
  logic [4:0] evt = '0;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [9:0] m_mask = '0, m_sticky = '0;
  logic [5:0] m_trig = 6'h20;

  always #5 clk = ~clk;

  uart_irq_ctrl u_uart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_count_i(cnt), .tx_empty_i(txe),
    .tx_full_i(txf), .evt_overrun_i(evt[0]), .evt_frame_i(evt[1]),
    .evt_parity_i(evt[2]), .evt_timeout_i(evt[3]), .evt_modem_i(evt[4]),
    .irq_o(irq)
  );

  function automatic logic [4:0] live_f(input logic [CW-1:0] c, input logic [5:0] t,
                                        input logic e, input logic f);
    return {f, e, (c == CW'(DEPTH)), (c == 0), (6'(c) >= t)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // drive at falling edge, model the rising edge, compare at next falling edge
  task automatic step(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d,
                      input logic [CW-1:0] c, input logic e, input logic f,
                      input logic [4:0] ev, input string tag);
    logic [31:0] exp_rd;
    logic [4:0] lv;
    wr = w; rd = r; addr = a; wdata = d; cnt = c; txe = e; txf = f; evt = ev;
    lv = live_f(c, m_trig, e, f);
    case (a)
      8'h10:   exp_rd = 32'(m_mask);
      8'h14:   exp_rd = 32'(m_sticky);
      8'h20:   exp_rd = 32'(m_trig);
      8'h2C:   exp_rd = 32'(lv);
      default: exp_rd = '0;
    endcase
    m_sticky = {ev, lv} | (m_sticky & ~((w && a == 8'h14) ? d[9:0] : 10'h0));
    if (w && a == 8'h08) m_mask = m_mask | d[9:0];
    if (w && a == 8'h0C) m_mask = m_mask & ~d[9:0];
    if (w && a == 8'h20) m_trig = d[5:0];
    @(negedge clk);
    check("R10 irq", 32'(irq), 32'(|(m_mask & m_sticky)));
    if (r) check(tag, rdata, exp_rd);
    wr = 0; rd = 0; evt = '0;
  endtask

  task automatic quiet_rd(input logic [7:0] a, input string tag);
    step(0, 1, a, 0, CW'(1), 0, 0, 5'h0, tag);
  endtask

  task automatic quiet_wr(input logic [7:0] a, input logic [31:0] d);
    step(1, 0, a, d, CW'(1), 0, 0, 5'h0, "wr");
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [9];
    addrs = '{8'h08, 8'h0C, 8'h10, 8'h14, 8'h20, 8'h2C, 8'h00, 8'h30, 8'h04};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    check("R1 irq after reset", 32'(irq), 0);
    quiet_rd(8'h14, "R1 sticky reset");
    quiet_rd(8'h10, "R1 mask reset");
    quiet_rd(8'h20, "R1 trigger reset");
    // R11 trigger write and read back
    quiet_wr(8'h20, 32'h0000_0003);
    quiet_rd(8'h20, "R11 trigger readback");
    // R2 live status encodings
    step(0, 1, 8'h2C, 0, CW'(3), 0, 0, 0, "R2 live at trigger");
    step(0, 1, 8'h2C, 0, CW'(0), 0, 0, 0, "R2 live rx empty");
    step(0, 1, 8'h2C, 0, CW'(DEPTH), 0, 0, 0, "R2 live rx full");
    step(0, 1, 8'h2C, 0, CW'(1), 1, 0, 0, "R2 live tx empty");
    step(0, 1, 8'h2C, 0, CW'(1), 0, 1, 0, "R2 live tx full");
    // R3 sticky holds after conditions gone
    quiet_rd(8'h14, "R3 sticky holds");
    // R7 write to live status ignored
    quiet_wr(8'h2C, 32'hFFFF_FFFF);
    quiet_rd(8'h14, "R7 live write ignored");
    // R8 clear subset, then all
    quiet_wr(8'h14, 32'h0000_0005);
    quiet_rd(8'h14, "R8 partial clear");
    quiet_wr(8'h14, 32'h0000_03FF);
    quiet_rd(8'h14, "R8 full clear");
    // R4 each event bit
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 8'h00, 0, CW'(1), 0, 0, 5'(1 << i), "evt");
      quiet_rd(8'h14, "R4 event bit");
      quiet_wr(8'h14, 32'h0000_03FF);
    end
    // R5 / R7 / R6 mask access
    quiet_wr(8'h08, 32'hFFFF_F0A0);
    quiet_rd(8'h10, "R5 mask set");
    quiet_wr(8'h10, 32'h0000_FFFF);
    quiet_rd(8'h10, "R7 mask direct write ignored");
    quiet_wr(8'h0C, 32'h0000_0020);
    quiet_rd(8'h10, "R6 mask clear");
    quiet_rd(8'h08, "R12 set register reads zero");
    // R9 set wins over same-edge clear, R10 irq from it
    quiet_wr(8'h08, 32'h0000_0008);
    step(1, 0, 8'h14, 32'h0000_0008, CW'(1), 1, 0, 0, "R9 set vs clear");
    quiet_rd(8'h14, "R9 sticky kept");
    check("R10 irq raised", 32'(irq), 1);
    quiet_wr(8'h14, 32'h0000_0008);
    check("R10 irq dropped", 32'(irq), 0);
    // R12 read and write same edge returns old value
    step(1, 1, 8'h20, 32'h0000_0011, CW'(1), 0, 0, 0, "R12 read before write");
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] a;
      logic [31:0] d;
      logic [CW-1:0] c;
      logic w, r, e, f;
      logic [4:0] ev;
      a = addrs[$urandom_range(0, 8)];
      d = $urandom();
      if (a == 8'h20) d = 32'($urandom_range(0, 20));
      c = ($urandom_range(0, 9) == 0) ? CW'(0) : CW'($urandom_range(1, DEPTH));
      e = ($urandom_range(0, 7) == 0);
      f = ($urandom_range(0, 7) == 0);
      for (int b = 0; b < 5; b++) ev[b] = ($urandom_range(0, 15) == 0);
      r = $urandom_range(0, 1);
      w = ($urandom_range(0, 2) == 0);
      step(w, r, a, d, c, e, f, ev, "R12 random read");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule